// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

A watchdog timer peripheral on a simple 32-bit register bus. Software programs a timeout length and enables the down-counter. It then reloads the counter from time to time by writing a restart code. Each write that changes state must carry a fixed magic code. A write with the wrong code is dropped and leaves all state unchanged. The counter moves once per pulse of a 32 kHz tick enable. One unit of the programmed timeout equals 512 ticks.

When the counter runs out, the block responds in one of three ways. It can drive a fixed-length system reset pulse, with a selectable polarity. It can raise an interrupt instead. In dual mode it raises the interrupt on the first expiry and drives the reset on a second expiry that is not preceded by a restart. A separate register lets software force a reset pulse at once. A status register, cleared when read, records whether the last reset came from a timeout or from software.

Top module: `keyed_wdog`

## Requirements
- R1: After rst_n is released, the block is in its idle state. The control register (offset 0x00) reads 0, the status register (0x0C) reads 0, the length register (0x04) reads 0x0000FFE0, the count register (0x10) reads 0x000FFE00, wdt_irq is 0 and sys_rst is 1.
- R2: A write to the control register at 0x00 is applied only when bits 31:24 equal 0x22. The control bits are: bit 0 run, bit 1 reset polarity, bit 2 reset output enable, bit 3 interrupt mode, bit 6 dual mode. A write with any other value in bits 31:24 leaves the register unchanged.
- R3: A write to the length register at 0x04 is applied only when bits 4:0 equal 0x08. The timeout field is bits 15:5, and a read returns that field in bits 15:5 with all other bits 0.
- R4: While the run bit is 0, tick pulses do not change the count register (0x10).
- R5: Writing exactly 0x00001971 to 0x08 loads the counter with the timeout field times 512. The count register at 0x10 returns the remaining count. A write of any other value to 0x08 does not reload the counter.
- R6: While the block runs, the counter drops by one on each tick. When a tick arrives with the count at 1 or below, that is an expiry, and the counter reloads. If interrupt mode and dual mode are both off and the output is enabled, sys_rst takes its active level from the clock edge of the expiry for exactly 8 clock cycles.
- R7: sys_rst is active-low when the polarity bit is 0 and active-high when it is 1. When no pulse is in progress, it sits at the opposite level.
- R8: With the reset output enable bit at 0, an expiry drives no reset pulse and leaves the status register unchanged.
- R9: With interrupt mode on and dual mode off, an expiry sets wdt_irq to 1 and drives no reset. A valid restart write clears wdt_irq.
- R10: In dual mode the first expiry sets wdt_irq. A second expiry with no restart in between drives the reset pulse. A valid restart between the two expiries cancels the second-stage reset.
- R11: Writing exactly 0x00001209 to 0x14 starts the reset pulse at that clock edge, whatever the run and output enable bits hold. Any other value written to 0x14 does nothing.
- R12: The status register reads 0x1 after a timeout reset and 0x2 after a software reset. Each read of it returns the value and then clears it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | 32 kHz tick enable, one clk cycle per tick |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data is returned on the next cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| wdt_irq | output | 1 | Watchdog interrupt, level |
| sys_rst | output | 1 | System reset request, polarity set by the control register |

## Verification
The counter is run to expiry under each response setting: plain reset, interrupt only, dual mode, and output disabled. Those runs tell apart the routes that end in a pulse from those that end in an interrupt or in nothing. A count of 511 ticks is checked against one of 512, which fixes the exact expiry edge. Each keyed register is also hit with a code one value off its key, which shows that the check covers the key value and not just the address. The pulse is driven under both polarity settings and is timed edge by edge for its length.

// File: rtl/keyed_wdog_pkg.sv
// Shared constants and types of the key-protected watchdog.
// Assumes a 32-bit bus with byte offsets on an 8-bit address.
package keyed_wdog_pkg;
    localparam logic [7:0]  OFS_CTRL  = 8'h00;
    localparam logic [7:0]  OFS_LEN   = 8'h04;
    localparam logic [7:0]  OFS_KICK  = 8'h08;
    localparam logic [7:0]  OFS_STAT  = 8'h0C;
    localparam logic [7:0]  OFS_CNT   = 8'h10;
    localparam logic [7:0]  OFS_SWR   = 8'h14;

    localparam logic [7:0]  CTRL_KEY  = 8'h22;
    localparam logic [4:0]  LEN_KEY   = 5'h08;
    localparam logic [31:0] KICK_CODE = 32'h0000_1971;
    localparam logic [31:0] SWR_CODE  = 32'h0000_1209;

    // Decoded control register.
    typedef struct packed {
        logic dual;
        logic irq_mode;
        logic out_en;
        logic pol_high;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/keyed_wdog_regs.sv
// Register decode and key checks of the watchdog.
// Holds the control, length and status registers and produces the
// one-cycle restart and software-reset strobes. Read data is registered.
// Assumes single-cycle writes and reads and no bus wait states.
module keyed_wdog_regs
    import keyed_wdog_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             ev_timeout,
    input  logic             ev_soft,
    output ctrl_t            ctrl,
    output logic [LEN_W-1:0] len_field,
    output logic             kick,
    output logic             sw_fire
);
    localparam int LEN_LSB = 5;

    logic       ctrl_ok;
    logic       len_ok;
    logic       stat_rd;
    logic [1:0] stat_q;
    logic [31:0] rd_mux;

    // Key qualification of every state-changing write.
    always_comb begin
        ctrl_ok = bus_wr && (bus_addr == OFS_CTRL) && (bus_wdata[31:24] == CTRL_KEY);
        len_ok  = bus_wr && (bus_addr == OFS_LEN)  && (bus_wdata[4:0] == LEN_KEY);
        kick    = bus_wr && (bus_addr == OFS_KICK) && (bus_wdata == KICK_CODE);
        sw_fire = bus_wr && (bus_addr == OFS_SWR)  && (bus_wdata == SWR_CODE);
        stat_rd = bus_rd && (bus_addr == OFS_STAT);
    end

    // Read data selection.
    always_comb begin
        rd_mux = '0;
        unique case (bus_addr)
            OFS_CTRL: rd_mux = {25'd0, ctrl.dual, 2'b00, ctrl.irq_mode,
                                ctrl.out_en, ctrl.pol_high, ctrl.run};
            OFS_LEN:  rd_mux = 32'(len_field) << LEN_LSB;
            OFS_STAT: rd_mux = {30'd0, stat_q};
            OFS_CNT:  rd_mux = 32'(cnt_val);
            default:  rd_mux = '0;
        endcase
    end

    // Control and length registers, updated only on a matching key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl      <= '0;
            len_field <= '1;
        end else begin
            if (ctrl_ok) begin
                ctrl.run      <= bus_wdata[0];
                ctrl.pol_high <= bus_wdata[1];
                ctrl.out_en   <= bus_wdata[2];
                ctrl.irq_mode <= bus_wdata[3];
                ctrl.dual     <= bus_wdata[6];
            end
            if (len_ok) begin
                len_field <= bus_wdata[LEN_LSB +: LEN_W];
            end
        end
    end

    // Reset-cause status, cleared by a read unless a new event arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (ev_soft) begin
            stat_q <= 2'b10;
        end else if (ev_timeout) begin
            stat_q <= 2'b01;
        end else if (stat_rd) begin
            stat_q <= 2'b00;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end else begin
            bus_rdata <= '0;
        end
    end

    AST_BADKEY_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTRL && bus_wdata[31:24] != CTRL_KEY) |=> $stable(ctrl)); // R2
    AST_BADKEY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_LEN && bus_wdata[4:0] != LEN_KEY) |=> $stable(len_field)); // R3
    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !ev_soft && !ev_timeout) |=> (stat_q == 2'b00)); // R12
endmodule

// File: rtl/keyed_wdog_counter.sv
// Timeout down-counter of the watchdog.
// Reloads to len_field * 2**UNIT_SHIFT on a restart or on expiry, and
// moves by one per tick while running. Expiry is a tick seen with the
// count at 1 or below. Assumes tick is a one-cycle enable in clk.
module keyed_wdog_counter
    import keyed_wdog_pkg::*;
#(
    parameter int LEN_W      = 11,
    parameter int UNIT_SHIFT = 9,
    parameter int CNT_W      = LEN_W + UNIT_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             kick,
    input  logic [LEN_W-1:0] len_field,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);
    logic [CNT_W-1:0] reload_val;

    // Reload value and expiry detection.
    always_comb begin
        reload_val = {len_field, {UNIT_SHIFT{1'b0}}};
        expire     = run && tick && !kick && (cnt <= CNT_W'(1));
    end

    // Counter update: restart wins over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= {{LEN_W{1'b1}}, {UNIT_SHIFT{1'b0}}};
        end else if (kick || expire) begin
            cnt <= reload_val;
        end else if (run && tick) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !kick) |=> $stable(cnt)); // R4
    AST_KICK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt[UNIT_SHIFT-1:0] == '0 && cnt[CNT_W-1:UNIT_SHIFT] == $past(len_field))); // R5
endmodule

// File: rtl/keyed_wdog_resp.sv
// Expiry response of the watchdog: interrupt, dual-stage escalation
// and a fixed-length reset pulse with selectable polarity.
// Assumes expire and kick are never high together (counter gives kick priority).
module keyed_wdog_resp
    import keyed_wdog_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  expire,
    input  logic  kick,
    input  logic  sw_fire,
    input  ctrl_t ctrl,
    output logic  wdt_irq,
    output logic  sys_rst,
    output logic  ev_timeout,
    output logic  ev_soft
);
    localparam int PW = $clog2(RST_CYCLES + 1);

    logic          stage_q;
    logic          irq_q;
    logic [PW-1:0] pulse_cnt;
    logic          pulse_on;
    logic          fire_to;
    logic          stage_set;
    logic          irq_set;
    logic          start_pulse;

    // Choose the response to an expiry from the current mode.
    always_comb begin
        fire_to   = 1'b0;
        stage_set = 1'b0;
        irq_set   = 1'b0;
        if (expire) begin
            if (ctrl.dual) begin
                if (stage_q) begin
                    fire_to = 1'b1;
                end else begin
                    stage_set = 1'b1;
                    irq_set   = 1'b1;
                end
            end else if (ctrl.irq_mode) begin
                irq_set = 1'b1;
            end else begin
                fire_to = 1'b1;
            end
        end
        ev_soft     = sw_fire;
        ev_timeout  = fire_to && ctrl.out_en && !sw_fire;
        start_pulse = sw_fire || (fire_to && ctrl.out_en);
    end

    // Interrupt and dual-stage flags; a restart clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= 1'b0;
            irq_q   <= 1'b0;
        end else if (kick) begin
            stage_q <= 1'b0;
            irq_q   <= 1'b0;
        end else if (fire_to) begin
            stage_q <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            if (stage_set) stage_q <= 1'b1;
            if (irq_set)   irq_q   <= 1'b1;
        end
    end

    // Reset pulse length counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_cnt <= '0;
        end else if (start_pulse) begin
            pulse_cnt <= PW'(RST_CYCLES);
        end else if (pulse_cnt != '0) begin
            pulse_cnt <= pulse_cnt - PW'(1);
        end
    end

    // Output levels.
    always_comb begin
        pulse_on = (pulse_cnt != '0);
        sys_rst  = pulse_on ? ctrl.pol_high : !ctrl.pol_high;
        wdt_irq  = irq_q;
    end

    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        sw_fire |=> (sys_rst == ctrl.pol_high)); // R11
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_cnt == '0) |-> (sys_rst != ctrl.pol_high)); // R7
    AST_IRQ_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !ctrl.dual && ctrl.irq_mode && !sw_fire && pulse_cnt == '0) |=> (irq_q && pulse_cnt == '0)); // R9
    AST_DUAL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctrl.dual && !stage_q) |=> irq_q); // R10
    AST_NO_OUT_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.out_en |-> !ev_timeout); // R8
endmodule

// File: rtl/keyed_wdog.sv
// Top of the key-protected watchdog timer.
// Connects register decode, down-counter and expiry response.
// Assumes tick is synchronous to clk and one cycle wide per slow tick.
module keyed_wdog
    import keyed_wdog_pkg::*;
#(
    parameter int LEN_W      = 11,
    parameter int UNIT_SHIFT = 9,
    parameter int RST_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wdt_irq,
    output logic        sys_rst
);
    localparam int CNT_W = LEN_W + UNIT_SHIFT;

    ctrl_t            ctrl;
    logic [LEN_W-1:0] len_field;
    logic [CNT_W-1:0] cnt;
    logic             kick;
    logic             sw_fire;
    logic             expire;
    logic             ev_timeout;
    logic             ev_soft;

    keyed_wdog_regs #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cnt_val    (cnt),
        .ev_timeout (ev_timeout),
        .ev_soft    (ev_soft),
        .ctrl       (ctrl),
        .len_field  (len_field),
        .kick       (kick),
        .sw_fire    (sw_fire)
    );

    keyed_wdog_counter #(.LEN_W(LEN_W), .UNIT_SHIFT(UNIT_SHIFT), .CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .run       (ctrl.run),
        .kick      (kick),
        .len_field (len_field),
        .cnt       (cnt),
        .expire    (expire)
    );

    keyed_wdog_resp #(.RST_CYCLES(RST_CYCLES)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire     (expire),
        .kick       (kick),
        .sw_fire    (sw_fire),
        .ctrl       (ctrl),
        .wdt_irq    (wdt_irq),
        .sys_rst    (sys_rst),
        .ev_timeout (ev_timeout),
        .ev_soft    (ev_soft)
    );

    AST_TICK_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !kick) |=> $stable(cnt)); // R6
endmodule

// File: tb/keyed_wdog_test.sv
// Directed bench for the key-protected watchdog.
module keyed_wdog_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_irq;
    logic        sys_rst;

    int total = 0;
    int bad = 0;
    bit done = 0;

    keyed_wdog uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wdt_irq   (wdt_irq),
        .sys_rst   (sys_rst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk);
        #1 bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(posedge clk);
            #1 tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        chk("R1 sys_rst idle", 32'(sys_rst), 32'd1);
        chk("R1 irq idle", 32'(wdt_irq), 32'd0);
        rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
        rd(8'h0C, v); chk("R1 status", v, 32'h0);
        rd(8'h04, v); chk("R1 length", v, 32'h0000FFE0);
        rd(8'h10, v); chk("R1 count", v, 32'h000FFE00);
    endtask

    task automatic t_ctrl_key();
        logic [31:0] v;
        do_reset();
        wr(8'h00, 32'h2300_0045);
        rd(8'h00, v); chk("R2 bad key ignored", v, 32'h0);
        wr(8'h00, 32'h2200_004F);
        rd(8'h00, v); chk("R2 good key", v, 32'h0000_004F);
    endtask

    task automatic t_len_key();
        logic [31:0] v;
        do_reset();
        wr(8'h04, 32'h0000_0049);
        rd(8'h04, v); chk("R3 bad key ignored", v, 32'h0000FFE0);
        wr(8'h04, 32'h0000_0048);
        rd(8'h04, v); chk("R3 good key", v, 32'h0000_0040);
        wr(8'h08, 32'h0000_1971);
        rd(8'h10, v); chk("R5 reload 2 units", v, 32'd1024);
    endtask

    task automatic t_run_stop();
        logic [31:0] v;
        do_reset();
        wr(8'h04, 32'h0000_0028);
        wr(8'h08, 32'h0000_1971);
        rd(8'h10, v); chk("R5 reload 1 unit", v, 32'd512);
        ticks(100);
        rd(8'h10, v); chk("R4 stopped count holds", v, 32'd512);
        wr(8'h00, 32'h2200_0001);
        ticks(100);
        rd(8'h10, v); chk("R6 counts down", v, 32'd412);
        wr(8'h08, 32'h0000_1970);
        rd(8'h10, v); chk("R5 bad restart ignored", v, 32'd412);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        do_reset();
        wr(8'h04, 32'h0000_0028);
        wr(8'h00, 32'h2200_0005);
        wr(8'h08, 32'h0000_1971);
        ticks(511);
        chk("R6 no reset before expiry", 32'(sys_rst), 32'd1);
        ticks(1);
        chk("R6 reset at expiry", 32'(sys_rst), 32'd0);
        repeat (7) @(posedge clk);
        #1 chk("R6 pulse last cycle", 32'(sys_rst), 32'd0);
        @(posedge clk);
        #1 chk("R6 pulse ended", 32'(sys_rst), 32'd1);
        rd(8'h0C, v); chk("R12 timeout cause", v, 32'h1);
        rd(8'h0C, v); chk("R12 cleared on read", v, 32'h0);
    endtask

    task automatic t_polarity();
        do_reset();
        wr(8'h04, 32'h0000_0028);
        wr(8'h00, 32'h2200_0007);
        wr(8'h08, 32'h0000_1971);
        chk("R7 idle low when active-high", 32'(sys_rst), 32'd0);
        ticks(512);
        chk("R7 active-high pulse", 32'(sys_rst), 32'd1);
    endtask

    task automatic t_out_off();
        logic [31:0] v;
        do_reset();
        wr(8'h04, 32'h0000_0028);
        wr(8'h00, 32'h2200_0001);
        wr(8'h08, 32'h0000_1971);
        ticks(512);
        chk("R8 no pulse when output off", 32'(sys_rst), 32'd1);
        rd(8'h0C, v); chk("R8 status untouched", v, 32'h0);
    endtask

    task automatic t_irq();
        do_reset();
        wr(8'h04, 32'h0000_0028);
        wr(8'h00, 32'h2200_000D);
        wr(8'h08, 32'h0000_1971);
        ticks(512);
        chk("R9 irq raised", 32'(wdt_irq), 32'd1);
        chk("R9 no reset", 32'(sys_rst), 32'd1);
        wr(8'h08, 32'h0000_1971);
        chk("R9 restart clears irq", 32'(wdt_irq), 32'd0);
    endtask

    task automatic t_dual();
        do_reset();
        wr(8'h04, 32'h0000_0028);
        wr(8'h00, 32'h2200_0045);
        wr(8'h08, 32'h0000_1971);
        ticks(512);
        chk("R10 first expiry irq", 32'(wdt_irq), 32'd1);
        chk("R10 first expiry no reset", 32'(sys_rst), 32'd1);
        ticks(512);
        chk("R10 second expiry reset", 32'(sys_rst), 32'd0);
        repeat (10) @(posedge clk);
        wr(8'h08, 32'h0000_1971);
        ticks(512);
        chk("R10 irq again", 32'(wdt_irq), 32'd1);
        wr(8'h08, 32'h0000_1971);
        ticks(512);
        chk("R10 restart cancels escalation", 32'(sys_rst), 32'd1);
    endtask

    task automatic t_soft();
        logic [31:0] v;
        do_reset();
        wr(8'h14, 32'h0000_1208);
        chk("R11 bad code ignored", 32'(sys_rst), 32'd1);
        wr(8'h14, 32'h0000_1209);
        chk("R11 immediate reset", 32'(sys_rst), 32'd0);
        repeat (8) @(posedge clk);
        #1 chk("R11 pulse ended", 32'(sys_rst), 32'd1);
        rd(8'h0C, v); chk("R12 software cause", v, 32'h2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_ctrl_key();
        t_len_key();
        t_run_stop();
        t_timeout();
        t_polarity();
        t_out_off();
        t_irq();
        t_dual();
        t_soft();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule